// File: doc/BRIEF.md
# Paired Double-Word Adder/Subtractor on 32-bit Lanes

This block adds or subtracts two 128-bit operands that each hold a pair of 64-bit integers, but its arithmetic is done entirely by 32-bit lane adders. It has no carry chain wider than one lane. The first pass works on each lane alone. It produces a partial result and, for each lane, one bit that says whether the lane carried out (add) or completed without a borrow (subtract). A fixed permute then moves the bit from the low word of each 64-bit value into the high word of that value. The second pass adds that bit to the partial result, or subtracts it.

Words are numbered in big-endian order. Word 0 holds bits [127:96] and word 3 holds bits [31:0]. Words 0 and 1 make up the first 64-bit value (bits [127:64]) and words 2 and 3 make up the second (bits [63:0]). The two passes are separated by a pipeline register. A request with `valid_i` high produces `valid_o` and the result two clock edges later.

Top module: `dw_pair_addsub`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it is released, `valid_o` is 0 and `res_o` is all zeros.
- R2: `valid_o` is high exactly when `valid_i` was high at the clock edge two edges earlier.
- R3: When `op_i` = 0 (add), bits [127:64] of `res_o` equal (a[127:64] + b[127:64]) mod 2^64, and bits [63:0] equal (a[63:0] + b[63:0]) mod 2^64.
- R4: When `op_i` = 1 (subtract), bits [127:64] of `res_o` equal (a[127:64] - b[127:64]) mod 2^64, and bits [63:0] equal (a[63:0] - b[63:0]) mod 2^64.
- R5: A carry out of word 1 goes into word 0, and a carry out of word 3 goes into word 2. Example: low words 0xFFFFFFFF + 0x00000001 give a low word of 0 and a high word incremented by one.
- R6: A borrow out of word 1 is taken from word 0, and a borrow out of word 3 is taken from word 2. Example: 0x00000001_00000000 - 1 gives 0x00000000_FFFFFFFF.
- R7: A carry or borrow out of word 0 or word 2 is discarded. It never reaches the other 64-bit value. Example: 0xFFFFFFFF_FFFFFFFF + 1 in the low double word gives 0 there and leaves bits [127:64] equal to their own sum.
- R8: When `valid_i` is low at an edge, `res_o` holds its value across the edge one later, whatever the values on `a_i`, `b_i` and `op_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op are valid |
| op_i | input | 1 | 0 = add, 1 = subtract |
| a_i | input | 128 | First operand, word 0 in bits [127:96] |
| b_i | input | 128 | Second operand, same layout |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Two 64-bit results, same layout |

## Verification
A result is due on the second rising edge after the edge that samples `valid_i`. After that edge nothing further happens until more stimulus arrives.

The bench drives inputs on falling edges. One falling edge after the request, it confirms that `valid_o` is still low. One falling edge later, it compares the output against native 64-bit arithmetic computed in the bench.

Between requests it changes the operands with `valid_i` low. It then checks that `valid_o` stays low and that `res_o` does not move. This separates the one-cycle and two-cycle paths and exercises the hold behaviour.

// File: rtl/paired_arith_pkg.sv
package paired_arith_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // big-endian word w sits at this bit offset in a vector of n words
  function automatic int word_lsb(input int w, input int n, input int lane_w);
    return (n - 1 - w) * lane_w;
  endfunction
endpackage

// File: rtl/lane_pass1.sv
module lane_pass1 #(
  parameter int LANE_W  = 32,
  parameter int N_LANES = 4,
  localparam int VEC_W  = LANE_W * N_LANES
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  input  logic               sub_i,
  output logic [VEC_W-1:0]   part_o,
  output logic [N_LANES-1:0] ind_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] b_eff;
    logic [LANE_W:0]   wide;
    assign b_eff = sub_i ? ~b_i[l*LANE_W +: LANE_W] : b_i[l*LANE_W +: LANE_W];
    assign wide  = {1'b0, a_i[l*LANE_W +: LANE_W]} + {1'b0, b_eff} + {{LANE_W{1'b0}}, sub_i};
    assign part_o[l*LANE_W +: LANE_W] = wide[LANE_W-1:0];
    // add: carry out; sub: 1 means no borrow
    assign ind_o[l] = wide[LANE_W];
  end
endmodule

// File: rtl/carry_move.sv
module carry_move #(
  parameter int LANE_W  = 32,
  parameter int N_LANES = 4,
  localparam int VEC_W  = LANE_W * N_LANES,
  localparam int N_PAIRS = N_LANES / 2
) (
  input  logic [N_LANES-1:0] ind_i,
  input  logic               sub_i,
  output logic [VEC_W-1:0]   move_o
);
  import paired_arith_pkg::*;

  logic [N_LANES-1:0] bits;
  // a borrow is the complement of the no-borrow indicator
  assign bits = sub_i ? ~ind_i : ind_i;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    localparam int HI_W  = 2 * p;
    localparam int LO_W  = 2 * p + 1;
    localparam int HI_LS = word_lsb(HI_W, N_LANES, LANE_W);
    localparam int LO_LS = word_lsb(LO_W, N_LANES, LANE_W);
    // low word's carry goes up into the high word; the high word's own carry is dropped
    assign move_o[HI_LS +: LANE_W] = {{(LANE_W-1){1'b0}}, bits[LO_LS/LANE_W]};
    assign move_o[LO_LS +: LANE_W] = '0;
  end
endmodule

// File: rtl/lane_pass2.sv
module lane_pass2 #(
  parameter int LANE_W  = 32,
  parameter int N_LANES = 4,
  localparam int VEC_W  = LANE_W * N_LANES
) (
  input  logic [VEC_W-1:0] part_i,
  input  logic [VEC_W-1:0] move_i,
  input  logic             sub_i,
  output logic [VEC_W-1:0] res_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign res_o[l*LANE_W +: LANE_W] = sub_i
      ? part_i[l*LANE_W +: LANE_W] - move_i[l*LANE_W +: LANE_W]
      : part_i[l*LANE_W +: LANE_W] + move_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/dw_pair_addsub.sv
module dw_pair_addsub #(
  parameter int LANE_W  = 32,
  parameter int N_LANES = 4,
  localparam int VEC_W  = LANE_W * N_LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  import paired_arith_pkg::*;

  op_e                op_in;
  logic               sub_in;
  logic [VEC_W-1:0]   part_d;
  logic [N_LANES-1:0] ind_d;
  logic [VEC_W-1:0]   move_d;

  assign op_in  = op_e'(op_i);
  assign sub_in = (op_in == OP_SUB);

  lane_pass1 #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_pass1 (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_in), .part_o(part_d), .ind_o(ind_d)
  );

  carry_move #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_move (
    .ind_i(ind_d), .sub_i(sub_in), .move_o(move_d)
  );

  // stage 1 register: partial result and moved carries
  logic             s1_valid;
  logic             s1_sub;
  logic [VEC_W-1:0] s1_part;
  logic [VEC_W-1:0] s1_move;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sub   <= 1'b0;
      s1_part  <= '0;
      s1_move  <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sub  <= sub_in;
        s1_part <= part_d;
        s1_move <= move_d;
      end
    end
  end

  logic [VEC_W-1:0] fix_d;

  lane_pass2 #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_pass2 (
    .part_i(s1_part), .move_i(s1_move), .sub_i(s1_sub), .res_o(fix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) res_o <= fix_d;
    end
  end
endmodule

// File: rtl/dw_pair_addsub_chk.sv
module dw_pair_addsub_chk #(
  parameter int LANE_W  = 32,
  parameter int N_LANES = 4,
  localparam int VEC_W  = LANE_W * N_LANES,
  localparam int DW     = 2 * LANE_W,
  localparam int N_PAIRS = N_LANES / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             op_i,
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o
);
  logic [1:0]       v_q;
  logic [1:0]       op_q;
  logic [VEC_W-1:0] a_q1, b_q1, a_q2, b_q2;
  logic [VEC_W-1:0] exp_add, exp_sub;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= '0;
      op_q <= '0;
      a_q1 <= '0; b_q1 <= '0; a_q2 <= '0; b_q2 <= '0;
    end else begin
      v_q  <= {v_q[0], valid_i};
      op_q <= {op_q[0], op_i};
      a_q1 <= a_i;  b_q1 <= b_i;
      a_q2 <= a_q1; b_q2 <= b_q1;
    end
  end

  // native double-word reference
  always_comb begin
    for (int p = 0; p < N_PAIRS; p++) begin
      exp_add[p*DW +: DW] = a_q2[p*DW +: DW] + b_q2[p*DW +: DW];
      exp_sub[p*DW +: DW] = a_q2[p*DW +: DW] - b_q2[p*DW +: DW];
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_q[1]); // R2

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !op_q[1]) |-> (res_o == exp_add)); // R3

  AST_SUB_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_q[1]) |-> (res_o == exp_sub)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q[0] && !valid_i) |-> ##2 $stable(res_o)); // R8

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (!valid_o); // R1
endmodule

bind dw_pair_addsub dw_pair_addsub_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
);

// File: tb/tb_dw_pair_addsub.sv
module tb_dw_pair_addsub;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_i = 1'b0;
  logic [127:0] a_i = '0;
  logic [127:0] b_i = '0;
  logic         valid_o;
  logic [127:0] res_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  dw_pair_addsub dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [127:0] ref_val(input logic [127:0] a, input logic [127:0] b, input logic sub);
    logic [63:0] hi, lo;
    hi = sub ? a[127:64] - b[127:64] : a[127:64] + b[127:64];
    lo = sub ? a[63:0] - b[63:0] : a[63:0] + b[63:0];
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge; edge 1 fills stage 1, edge 2 the output
  task automatic run(input string req, input logic [127:0] a, input logic [127:0] b, input logic sub);
    logic [127:0] held;
    @(negedge clk_i);
    a_i = a; b_i = b; op_i = sub; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    a_i = ~a; b_i = ~b; op_i = ~sub;
    check("R2 valid_o one edge after request", {127'b0, valid_o}, 128'd0);
    @(negedge clk_i);
    check("R2 valid_o two edges after request", {127'b0, valid_o}, 128'd1);
    check(req, res_o, ref_val(a, b, sub));
    held = res_o;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 res_o held while idle", res_o, held);
    check("R8 valid_o low while idle", {127'b0, valid_o}, 128'd0);
  endtask

  initial begin
    logic [31:0] corner [8];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFE; corner[5] = 32'hFFFF_FFFF;
    corner[6] = 32'h0000_FFFF; corner[7] = 32'hFFFF_0000;

    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", {127'b0, valid_o}, 128'd0);
    check("R1 res_o in reset", res_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after release", {127'b0, valid_o}, 128'd0);
    check("R1 res_o after release", res_o, 128'd0);

    // R5: low word overflow into high word
    run("R5 carry word3->word2 and word1->word0",
        {32'h1, 32'hFFFF_FFFF, 32'h5, 32'hFFFF_FFFF},
        {32'h2, 32'h0000_0001, 32'h6, 32'h0000_0001}, 1'b0);
    check("R5 exact value", res_o, {32'h4, 32'h0, 32'hC, 32'h0});
    // R6: borrow across word boundary
    run("R6 borrow word3->word2",
        {64'h0, 32'h1, 32'h0}, {64'h0, 32'h0, 32'h1}, 1'b1);
    check("R6 exact value", res_o, {64'h0, 32'h0, 32'hFFFF_FFFF});
    run("R6 borrow word1->word0",
        {32'h0, 32'h0, 64'h0}, {32'h0, 32'h1, 64'h0}, 1'b1);
    check("R6 wrap value", res_o, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    // R7: top carry dropped, no leak between double words
    run("R7 add wrap low dword",
        {64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h2, 64'h1}, 1'b0);
    check("R7 exact value", res_o, {64'h3, 64'h0});
    run("R7 sub wrap low dword",
        {64'h9, 64'h0}, {64'h4, 64'h1}, 1'b1);
    check("R7 sub exact value", res_o, {64'h5, 64'hFFFF_FFFF_FFFF_FFFF});

    // sweep low-word corners of both double words, both ops
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 2; s++) begin
          logic [127:0] a, b;
          a = {$urandom, corner[i], $urandom, corner[j]};
          b = {$urandom, corner[j], $urandom, corner[i]};
          if (s == 0) run("R3 add corner sweep", a, b, 1'b0);
          else        run("R4 sub corner sweep", a, b, 1'b1);
        end

    // random patterns
    for (int k = 0; k < 300; k++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (k[0]) run("R4 sub random", a, b, 1'b1);
      else      run("R3 add random", a, b, 1'b0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule